// File: doc/BRIEF.md
# Keyed configuration data port

This block lets firmware fetch configuration items by number through two small register windows. A 16-bit write to the control window picks an item by key. Each 8-bit read of the data window then returns the next byte of that item. A cursor inside the block advances on its own, so firmware reads an item as a plain byte stream. Items sit in two banks: a generic one and one reserved for architecture-specific data. Both banks use the same index range. Every item has its own length and start address inside a shared byte store.

Some items act as mailboxes. When the selecting key carries the write flag, data-window byte writes fill the item from its first byte onward. The write that fills the last byte raises a one-cycle completion strobe. The strobe names the bank and index of the item, so that neighbouring logic can use the buffer. The cursor then returns to the start of the item.

A preload port fills the byte store before use. A descriptor port sets each item's start address and length. Multi-byte numbers are preloaded least-significant byte first, so they stream out in that order.

Top module: `fwc_cfg_port`

## Requirements
- R1: After reset the selection is key 0x0000 with the cursor at zero. `sel_hit_o` is 1, and the first data read returns byte 0 of bank 0, index 0.
- R2: A 16-bit write to the control window (`bus_win_i`=0, `bus_half_i`=1) loads the key and always sets the cursor to zero. Selecting the same key again restarts the item at byte 0.
- R3: A key whose bits 13:0 are 32 or more is stored as the invalid selection 0xFFFF and drives `sel_hit_o` low. While the selection is invalid, reads return 0x00 and writes have no effect.
- R4: Key bit 15 chooses the bank (0 = generic, 1 = architecture-local). The same index in the two banks names two separate items.
- R5: An 8-bit data-window read (`bus_win_i`=1, `bus_half_i`=0) returns the byte at the item's start address plus the cursor, then adds one to the cursor.
- R6: A data read returns 0x00 and leaves the cursor unchanged when the cursor is at or past the item length. The same holds for an item of length 0.
- R7: An 8-bit data-window write stores its low byte at the item's start address plus the cursor and adds one to the cursor. It does so only if key bit 14 is set and the cursor is below the length; otherwise it is ignored.
- R8: A write that brings the cursor up to the item length pulses `done_o` for one cycle, one clock after the write. The pulse carries the item's bank on `done_bank_o` and its index on `done_idx_o`, and the cursor returns to zero.
- R9: The following accesses change neither the key nor the cursor: an 8-bit control write, any read of the control window, and a 16-bit data-window read or write. Such reads return 0x00.
- R10: Every read request gets exactly one `rsp_valid_o` pulse, one clock later. Writes get no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_valid_i | input | 1 | Access request this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_win_i | input | 1 | Window select: 0 = control, 1 = data |
| bus_half_i | input | 1 | Access size: 1 = 16-bit, 0 = 8-bit |
| bus_wdata_i | input | 16 | Write data (key, or data byte in bits 7:0) |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_rdata_o | output | 8 | Read response byte |
| sel_hit_o | output | 1 | Current selection is a valid item |
| done_o | output | 1 | Writable item filled |
| done_bank_o | output | 1 | Bank of the filled item |
| done_idx_o | output | IDX_W | Index of the filled item |
| pl_we_i | input | 1 | Byte store preload write |
| pl_addr_i | input | AW | Preload address |
| pl_data_i | input | 8 | Preload byte |
| dsc_we_i | input | 1 | Descriptor write |
| dsc_bank_i | input | 1 | Descriptor bank |
| dsc_idx_i | input | IDX_W | Descriptor index |
| dsc_base_i | input | AW | Item start address in the byte store |
| dsc_len_i | input | LEN_W | Item length in bytes (0 = no data) |

## Verification
The hardest condition to reach is the rewind after a fill. Seen from outside, it only shows when a further write lands on byte 0 rather than being dropped. The stimulus therefore fills a three-byte writable item, writes one more byte, and then reselects the item without the write flag to read it back. Two back-to-back writes to a one-byte item in the second bank check that completion strobes can follow each other on consecutive cycles. Ignored access sizes sit between ordinary reads of a known 64-bit item, so any slip of the cursor shows up as a wrong byte.

// File: rtl/fwc_pkg.sv
package fwc_pkg;
  localparam int          KEY_W       = 16;
  localparam int          BANK_BIT    = 15;
  localparam int          WR_BIT      = 14;
  localparam int          IDX_FIELD_W = 14;
  localparam logic [15:0] KEY_INVALID = 16'hFFFF;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_SEL,
    ACC_RD,
    ACC_WR
  } acc_e;

  // only exact-size accesses to each window do anything
  function automatic acc_e classify(input logic valid, input logic write,
                                    input logic win, input logic half);
    acc_e a;
    a = ACC_NONE;
    if (valid) begin
      if (!win && write && half)       a = ACC_SEL;
      else if (win && !half && !write) a = ACC_RD;
      else if (win && !half && write)  a = ACC_WR;
    end
    return a;
  endfunction
endpackage

// File: rtl/fwc_desc_table.sv
module fwc_desc_table #(
  parameter int NUM_ENTRIES = 32,
  parameter int AW          = 8,
  parameter int LEN_W       = 16,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             wbank_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [AW-1:0]    wbase_i,
  input  logic [LEN_W-1:0] wlen_i,
  input  logic             rbank_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [AW-1:0]    rbase_o,
  output logic [LEN_W-1:0] rlen_o
);
  localparam int NBANK = 2;

  logic [AW-1:0]    bank_base [NBANK];
  logic [LEN_W-1:0] bank_len  [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [AW-1:0]    base_q [NUM_ENTRIES];
    logic [LEN_W-1:0] len_q  [NUM_ENTRIES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < NUM_ENTRIES; i++) begin
          base_q[i] <= '0;
          len_q[i]  <= '0;
        end
      end else if (we_i && (wbank_i == b[0])) begin
        base_q[widx_i] <= wbase_i;
        len_q[widx_i]  <= wlen_i;
      end
    end

    assign bank_base[b] = base_q[ridx_i];
    assign bank_len[b]  = len_q[ridx_i];
  end

  assign rbase_o = bank_base[rbank_i];
  assign rlen_o  = bank_len[rbank_i];
endmodule

// File: rtl/fwc_byte_ram.sv
module fwc_byte_ram #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          pl_we_i,
  input  logic [AW-1:0] pl_addr_i,
  input  logic [7:0]    pl_data_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [7:0]    bus_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);
  logic [7:0] mem_q [DEPTH];

  // preload takes the single write port when both request it
  always_ff @(posedge clk_i) begin
    if (pl_we_i)       mem_q[pl_addr_i]  <= pl_data_i;
    else if (bus_we_i) mem_q[bus_addr_i] <= bus_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/fwc_cursor.sv
module fwc_cursor
  import fwc_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int AW          = 8,
  parameter int LEN_W       = 16,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_valid_i,
  input  logic             bus_write_i,
  input  logic             bus_win_i,
  input  logic             bus_half_i,
  input  logic [15:0]      bus_wdata_i,
  input  logic [AW-1:0]    ent_base_i,
  input  logic [LEN_W-1:0] ent_len_i,
  input  logic [7:0]       ram_rdata_i,
  output logic             ent_bank_o,
  output logic [IDX_W-1:0] ent_idx_o,
  output logic [AW-1:0]    ram_addr_o,
  output logic             ram_we_o,
  output logic [7:0]       ram_wdata_o,
  output logic             rsp_valid_o,
  output logic [7:0]       rsp_rdata_o,
  output logic             sel_hit_o,
  output logic             done_o,
  output logic             done_bank_o,
  output logic [IDX_W-1:0] done_idx_o
);
  logic [KEY_W-1:0] key_q;
  logic [LEN_W-1:0] off_q, off_d;
  logic [LEN_W:0]   off_inc;
  logic             in_range, rd_ok, wr_ok, fill_last;
  acc_e             acc;

  assign acc       = classify(bus_valid_i, bus_write_i, bus_win_i, bus_half_i);
  assign sel_hit_o = (key_q != KEY_INVALID);
  assign in_range  = (off_q < ent_len_i);
  assign off_inc   = {1'b0, off_q} + 1'b1;
  assign fill_last = (off_inc == {1'b0, ent_len_i});

  assign rd_ok = (acc == ACC_RD) && sel_hit_o && in_range;
  assign wr_ok = (acc == ACC_WR) && sel_hit_o && key_q[WR_BIT] && in_range;

  assign ent_bank_o  = key_q[BANK_BIT];
  assign ent_idx_o   = key_q[IDX_W-1:0];
  assign ram_addr_o  = ent_base_i + AW'(off_q);
  assign ram_we_o    = wr_ok;
  assign ram_wdata_o = bus_wdata_i[7:0];

  always_comb begin
    off_d = off_q;
    if (acc == ACC_SEL)  off_d = '0;
    else if (rd_ok)      off_d = off_inc[LEN_W-1:0];
    else if (wr_ok)      off_d = fill_last ? '0 : off_inc[LEN_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q <= '0;
      off_q <= '0;
    end else begin
      off_q <= off_d;
      if (acc == ACC_SEL) begin
        if (bus_wdata_i[IDX_FIELD_W-1:0] >= IDX_FIELD_W'(NUM_ENTRIES)) key_q <= KEY_INVALID;
        else                                                           key_q <= bus_wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      done_o      <= 1'b0;
      done_bank_o <= 1'b0;
      done_idx_o  <= '0;
    end else begin
      rsp_valid_o <= bus_valid_i && !bus_write_i;
      rsp_rdata_o <= rd_ok ? ram_rdata_i : 8'h00;
      done_o      <= wr_ok && fill_last;
      if (wr_ok && fill_last) begin
        done_bank_o <= key_q[BANK_BIT];
        done_idx_o  <= key_q[IDX_W-1:0];
      end
    end
  end

  AST_RSP_FOLLOWS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && !bus_write_i) |=> rsp_valid_o); // R10
  AST_RSP_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(bus_valid_i && !bus_write_i)); // R10
  AST_SEL_REWINDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc == ACC_SEL) |=> (off_q == '0)); // R2
  AST_INVALID_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((acc == ACC_RD) && !sel_hit_o) |=> (rsp_rdata_o == 8'h00)); // R3
  AST_DEAD_READ_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((acc == ACC_RD) && !in_range) |=> $stable(off_q)); // R6
  AST_WRITE_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (sel_hit_o && key_q[WR_BIT])); // R7
  AST_DONE_REWINDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (off_q == '0)); // R8
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(ram_we_o)); // R8
  AST_IGNORED_KEEPS_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && (acc != ACC_SEL)) |=> $stable(key_q)); // R9
endmodule

// File: rtl/fwc_cfg_port.sv
module fwc_cfg_port #(
  parameter int NUM_ENTRIES = 32,
  parameter int DATA_DEPTH  = 256,
  parameter int LEN_W       = 16,
  localparam int AW         = $clog2(DATA_DEPTH),
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_valid_i,
  input  logic             bus_write_i,
  input  logic             bus_win_i,
  input  logic             bus_half_i,
  input  logic [15:0]      bus_wdata_i,
  output logic             rsp_valid_o,
  output logic [7:0]       rsp_rdata_o,
  output logic             sel_hit_o,
  output logic             done_o,
  output logic             done_bank_o,
  output logic [IDX_W-1:0] done_idx_o,
  input  logic             pl_we_i,
  input  logic [AW-1:0]    pl_addr_i,
  input  logic [7:0]       pl_data_i,
  input  logic             dsc_we_i,
  input  logic             dsc_bank_i,
  input  logic [IDX_W-1:0] dsc_idx_i,
  input  logic [AW-1:0]    dsc_base_i,
  input  logic [LEN_W-1:0] dsc_len_i
);
  logic             ent_bank;
  logic [IDX_W-1:0] ent_idx;
  logic [AW-1:0]    ent_base, ram_addr;
  logic [LEN_W-1:0] ent_len;
  logic [7:0]       ram_rdata, ram_wdata;
  logic             ram_we;

  fwc_desc_table #(
    .NUM_ENTRIES(NUM_ENTRIES), .AW(AW), .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) u_desc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (dsc_we_i),
    .wbank_i (dsc_bank_i),
    .widx_i  (dsc_idx_i),
    .wbase_i (dsc_base_i),
    .wlen_i  (dsc_len_i),
    .rbank_i (ent_bank),
    .ridx_i  (ent_idx),
    .rbase_o (ent_base),
    .rlen_o  (ent_len)
  );

  fwc_byte_ram #(
    .DEPTH(DATA_DEPTH), .AW(AW)
  ) u_ram (
    .clk_i      (clk_i),
    .pl_we_i    (pl_we_i),
    .pl_addr_i  (pl_addr_i),
    .pl_data_i  (pl_data_i),
    .bus_we_i   (ram_we),
    .bus_addr_i (ram_addr),
    .bus_data_i (ram_wdata),
    .rd_addr_i  (ram_addr),
    .rd_data_o  (ram_rdata)
  );

  fwc_cursor #(
    .NUM_ENTRIES(NUM_ENTRIES), .AW(AW), .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) u_cursor (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_valid_i (bus_valid_i),
    .bus_write_i (bus_write_i),
    .bus_win_i   (bus_win_i),
    .bus_half_i  (bus_half_i),
    .bus_wdata_i (bus_wdata_i),
    .ent_base_i  (ent_base),
    .ent_len_i   (ent_len),
    .ram_rdata_i (ram_rdata),
    .ent_bank_o  (ent_bank),
    .ent_idx_o   (ent_idx),
    .ram_addr_o  (ram_addr),
    .ram_we_o    (ram_we),
    .ram_wdata_o (ram_wdata),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o),
    .sel_hit_o   (sel_hit_o),
    .done_o      (done_o),
    .done_bank_o (done_bank_o),
    .done_idx_o  (done_idx_o)
  );
endmodule

// File: tb/fwc_cfg_port_test.sv
module fwc_cfg_port_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0, bus_win = 1'b0, bus_half = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        rsp_valid, sel_hit, done, done_bank;
  logic [7:0]  rsp_rdata;
  logic [4:0]  done_idx;
  logic        pl_we = 1'b0;
  logic [7:0]  pl_addr = '0, pl_data = '0;
  logic        dsc_we = 1'b0, dsc_bank = 1'b0;
  logic [4:0]  dsc_idx = '0;
  logic [7:0]  dsc_base = '0;
  logic [15:0] dsc_len = '0;

  always #5 clk = ~clk;

  fwc_cfg_port uut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_valid_i(bus_valid), .bus_write_i(bus_write), .bus_win_i(bus_win),
    .bus_half_i(bus_half), .bus_wdata_i(bus_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .sel_hit_o(sel_hit),
    .done_o(done), .done_bank_o(done_bank), .done_idx_o(done_idx),
    .pl_we_i(pl_we), .pl_addr_i(pl_addr), .pl_data_i(pl_data),
    .dsc_we_i(dsc_we), .dsc_bank_i(dsc_bank), .dsc_idx_i(dsc_idx),
    .dsc_base_i(dsc_base), .dsc_len_i(dsc_len)
  );

  typedef struct { logic [7:0] val; string req; } rd_exp_t;
  typedef struct { logic bank; logic [4:0] idx; string req; } dn_exp_t;
  rd_exp_t rq[$];
  dn_exp_t dq[$];
  int checks = 0, errors = 0;

  function automatic logic [7:0] f(input int a);
    return 8'((a * 3) + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pop expectations as responses and strobes appear
  always @(negedge clk) begin
    rd_exp_t r;
    dn_exp_t d;
    if (rst_n) begin
      if (rsp_valid) begin
        if (rq.size() == 0) chk(0, "R10", "response without read", rsp_rdata, 0);
        else begin
          r = rq.pop_front();
          chk(rsp_rdata == r.val, r.req, "read byte", rsp_rdata, r.val);
        end
      end
      if (done) begin
        if (dq.size() == 0) chk(0, "R8", "unexpected done", {done_bank, done_idx}, 0);
        else begin
          d = dq.pop_front();
          chk({done_bank, done_idx} == {d.bank, d.idx}, d.req, "done bank/idx",
              {done_bank, done_idx}, {d.bank, d.idx});
        end
      end
    end
  end

  task automatic bus(input logic wr, input logic win, input logic half, input logic [15:0] d);
    bus_valid = 1'b1; bus_write = wr; bus_win = win; bus_half = half; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic sel(input logic [15:0] k);
    bus(1'b1, 1'b0, 1'b1, k);
  endtask

  task automatic rd(input logic [7:0] e, input string req);
    rd_exp_t r;
    r.val = e; r.req = req;
    rq.push_back(r);
    bus(1'b0, 1'b1, 1'b0, 16'h0);
  endtask

  task automatic wr(input logic [7:0] d);
    bus(1'b1, 1'b1, 1'b0, {8'h00, d});
  endtask

  task automatic wr_done(input logic [7:0] d, input logic b, input logic [4:0] i, input string req);
    dn_exp_t e;
    e.bank = b; e.idx = i; e.req = req;
    dq.push_back(e);
    wr(d);
  endtask

  task automatic dsc(input logic b, input logic [4:0] i, input logic [7:0] base, input logic [15:0] len);
    dsc_we = 1'b1; dsc_bank = b; dsc_idx = i; dsc_base = base; dsc_len = len;
    @(negedge clk);
    dsc_we = 1'b0;
  endtask

  initial begin
    #100000;
    chk(0, "ALL", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] num;
    num = 64'h1122334455667788;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sel_hit == 1'b1, "R1", "sel_hit after reset", sel_hit, 1);
    chk(rsp_valid == 1'b0 && done == 1'b0, "R1", "idle outputs after reset", {rsp_valid, done}, 0);

    for (int a = 0; a < 256; a++) begin
      pl_we = 1'b1; pl_addr = 8'(a);
      pl_data = (a >= 8'h80 && a < 8'h88) ? num[8*(a-8'h80) +: 8] : f(a);
      @(negedge clk);
    end
    pl_we = 1'b0;
    dsc(1'b0, 5'd0,  8'h10, 16'd4);
    dsc(1'b1, 5'd0,  8'h40, 16'd2);
    dsc(1'b0, 5'd5,  8'h80, 16'd8);
    dsc(1'b0, 5'd7,  8'hA0, 16'd3);
    dsc(1'b1, 5'd31, 8'hC0, 16'd1);
    dsc(1'b0, 5'd3,  8'hD0, 16'd0);

    // R1: key 0 still selected, cursor at 0
    for (int i = 0; i < 4; i++) rd(f(8'h10 + i), "R1");
    rd(8'h00, "R6");
    rd(8'h00, "R6");

    // R5 / R2: 64-bit item streams LSB first, reselect restarts
    sel(16'h0005);
    rd(8'h88, "R5"); rd(8'h77, "R5");
    sel(16'h0005);
    for (int i = 0; i < 8; i++) rd(num[8*i +: 8], "R2");
    rd(8'h00, "R6");

    // R4: bank select
    sel(16'h8000);
    rd(f(8'h40), "R4"); rd(f(8'h41), "R4"); rd(8'h00, "R6");
    sel(16'h0000);
    rd(f(8'h10), "R4");

    // R3: invalid keys
    sel(16'h0020);
    chk(sel_hit == 1'b0, "R3", "sel_hit index 32", sel_hit, 0);
    rd(8'h00, "R3");
    sel(16'h3FFF);
    chk(sel_hit == 1'b0, "R3", "sel_hit index 0x3FFF", sel_hit, 0);
    sel(16'h801F);
    chk(sel_hit == 1'b1, "R3", "sel_hit index 31", sel_hit, 1);
    rd(f(8'hC0), "R4");
    sel(16'hFFFF);
    chk(sel_hit == 1'b0, "R3", "sel_hit 0xFFFF", sel_hit, 0);
    wr(8'h12);
    rd(8'h00, "R3");
    sel(16'h4020);
    wr(8'h99);

    // R6: empty item
    sel(16'h0003);
    rd(8'h00, "R6");
    sel(16'h4003);
    wr(8'h55);

    // R7 / R8: writable item
    sel(16'h0007);
    wr(8'hAA);
    sel(16'h0007);
    rd(f(8'hA0), "R7");
    sel(16'h4007);
    wr(8'h01); wr(8'h02);
    wr_done(8'h03, 1'b0, 5'd7, "R8");
    wr(8'h44);
    sel(16'h0007);
    rd(8'h44, "R8"); rd(8'h02, "R7"); rd(8'h03, "R7");

    // R8: back-to-back fills of a one-byte item in bank 1
    sel(16'hC01F);
    wr_done(8'h5C, 1'b1, 5'd31, "R8");
    wr_done(8'h6D, 1'b1, 5'd31, "R8");
    sel(16'h801F);
    rd(8'h6D, "R8");

    // R9: wrong-size and wrong-window accesses
    sel(16'h0005);
    rd(8'h88, "R9");
    bus(1'b1, 1'b0, 1'b0, 16'h0000);
    rd(8'h77, "R9");
    rq.push_back('{val: 8'h00, req: "R9"});
    bus(1'b0, 1'b1, 1'b1, 16'h0);
    rd(8'h66, "R9");
    rq.push_back('{val: 8'h00, req: "R9"});
    bus(1'b0, 1'b0, 1'b0, 16'h0);
    rd(8'h55, "R9");
    rq.push_back('{val: 8'h00, req: "R9"});
    bus(1'b0, 1'b0, 1'b1, 16'h0);
    rd(8'h44, "R9");
    sel(16'h4007);
    bus(1'b1, 1'b1, 1'b1, 16'h00EE);
    sel(16'h0007);
    rd(8'h44, "R9");

    repeat (3) @(negedge clk);
    chk(rq.size() == 0, "R10", "reads left unanswered", rq.size(), 0);
    chk(dq.size() == 0, "R8", "done strobes missing", dq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule